// File: doc/BRIEF.md
# Supply-Loss Protection Sequencer

This block turns two digitized supply-status flags into the protection signals a battery-backed timekeeping subsystem needs. One flag reports that the main supply is under the power-fail threshold. The other reports that it is under the lower battery-switchover threshold. From these two flags the block drives five things: an active-low system reset, a gate that holds the external RAM chip enable inactive, an inhibit on internal register access, a battery-select flag, and an output-drive enable. When the output-drive enable is low, the pins go to high impedance.

When the supply dips, protection takes effect in the next cycle after the synchronized flag shows it. Protection then holds for as long as the dip lasts. A deeper dip, below the switchover level, also selects the battery and releases the output drivers. Once the supply is good again, protection is not dropped at once. It stays for a programmed recovery interval counted in clock cycles. A new dip during that interval restarts the whole interval. On every entry into recovery, the block sends a one-cycle pulse to the clock core, so the core freezes its register updates and keeps the time at which power was lost.

Top module: `supply_guard`

## Requirements
- R1: Each status input passes through a two-flop synchronizer with registered outputs. A level change on an input, applied between clock edges, shows on the outputs after the third rising edge and not before.
- R2: While the synchronized power-fail flag is high, `sys_rst_n_o` is 0, `ram_ce_block_o` is 1 and `reg_inhibit_o` is 1, starting the cycle after the flag is seen.
- R3: Once the power-fail flag drops, protection is kept for exactly `REC_CYCLES` cycles in the recovery state. With the flags low from before rising edge E0, all three protection outputs release after edge E(2+REC_CYCLES).
- R4: If the power-fail flag rises again during recovery, even for one cycle, the recovery interval is abandoned. The full interval then restarts from the flag's next fall.
- R5: While the synchronized switchover flag is high, `bat_sel_o` is 1 and `out_en_o` is 0 (high impedance), together with all the protection of R2.
- R6: When the switchover flag clears, `bat_sel_o` returns to 0 and `out_en_o` to 1 while protection is held. Recovery begins only after the power-fail flag is also low.
- R7: `halt_set_o` is high for exactly one cycle on each entry into recovery, which is the cycle the recovery outputs first appear.
- R8: A synchronous reset (`rst` high) gives `sys_rst_n_o`=0, `ram_ce_block_o`=1, `reg_inhibit_o`=1, `bat_sel_o`=0, `out_en_o`=1 and `halt_set_o`=0. The synchronizer holds "power-fail present, switchover absent".
- R9: In normal operation, `sys_rst_n_o`=1, `ram_ce_block_o`=0, `reg_inhibit_o`=0, `bat_sel_o`=0 and `out_en_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_fail_i | input | 1 | Supply under power-fail threshold (asynchronous) |
| vcc_batt_i | input | 1 | Supply under battery-switchover threshold (asynchronous) |
| sys_rst_n_o | output | 1 | Active-low system reset |
| ram_ce_block_o | output | 1 | 1 forces the external RAM chip enable inactive |
| reg_inhibit_o | output | 1 | 1 blocks internal register reads and writes |
| bat_sel_o | output | 1 | 1 selects the battery supply |
| out_en_o | output | 1 | 1 drives outputs, 0 places them in high impedance |
| halt_set_o | output | 1 | One-cycle pulse that sets the clock core's update-halt bit |

## Verification
Directed cases cover the following situations:
- A steady dip, which shows the exact release edge and separates an off-by-one recovery count from a correct one.
- A one-cycle glitch during recovery, which separates a restarted interval from a resumed one.
- A deep dip followed by a partial return, which shows that battery select and the output drive are undone without dropping protection.
- A single input step from normal operation, which fixes the three-edge latency.

Random runs with seeded dip and return lengths, some shorter and some longer than the recovery interval, are compared every cycle against a bench model. These runs expose wrong transitions between the four operating states.

// File: rtl/supply_guard_pkg.sv
`timescale 1ns/1ps
package supply_guard_pkg;

  typedef enum logic [1:0] {
    SG_NORMAL  = 2'd0,
    SG_PROTECT = 2'd1,
    SG_BATTERY = 2'd2,
    SG_RECOVER = 2'd3
  } sg_state_e;

  typedef struct packed {
    logic rst_n;
    logic ram_block;
    logic reg_inhibit;
    logic bat_sel;
    logic out_en;
  } sg_ctl_t;

  function automatic sg_ctl_t sg_decode(sg_state_e s);
    sg_ctl_t c;
    c.rst_n       = 1'b0;
    c.ram_block   = 1'b1;
    c.reg_inhibit = 1'b1;
    c.bat_sel     = 1'b0;
    c.out_en      = 1'b1;
    case (s)
      SG_NORMAL: begin
        c.rst_n       = 1'b1;
        c.ram_block   = 1'b0;
        c.reg_inhibit = 1'b0;
      end
      SG_BATTERY: begin
        c.bat_sel = 1'b1;
        c.out_en  = 1'b0;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sg_sync.sv
`timescale 1ns/1ps
module sg_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sg_rec_timer.sv
`timescale 1ns/1ps
module sg_rec_timer #(
  parameter int REC_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);

  localparam int            CW   = (REC_CYCLES < 2) ? 1 : $clog2(REC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q <= LAST));

endmodule

// File: rtl/sg_out_stage.sv
`timescale 1ns/1ps
module sg_out_stage
  import supply_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sg_state_e cur_i,
  input  sg_state_e nxt_i,
  output sg_ctl_t   ctl_o,
  output logic      halt_o
);

  sg_ctl_t ctl_q;
  logic    halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= sg_decode(SG_PROTECT);
      halt_q <= 1'b0;
    end else begin
      ctl_q  <= sg_decode(nxt_i);
      halt_q <= (nxt_i == SG_RECOVER) && (cur_i != SG_RECOVER);
    end
  end

  assign ctl_o  = ctl_q;
  assign halt_o = halt_q;

  // R7
  halt_single_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> !halt_q);

endmodule

// File: rtl/supply_guard.sv
`timescale 1ns/1ps
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int REC_CYCLES  = 20_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_fail_i,
  input  logic vcc_batt_i,
  output logic sys_rst_n_o,
  output logic ram_ce_block_o,
  output logic reg_inhibit_o,
  output logic bat_sel_o,
  output logic out_en_o,
  output logic halt_set_o
);

  localparam int FAIL_B = 0;
  localparam int BATT_B = 1;

  logic [1:0] flags_s;
  logic       fail_s, batt_s, rec_done;
  sg_state_e  state_q, state_d;
  sg_ctl_t    ctl;

  sg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({vcc_batt_i, vcc_fail_i}),
    .q_o (flags_s)
  );

  assign fail_s = flags_s[FAIL_B];
  assign batt_s = flags_s[BATT_B];

  sg_rec_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (state_q == SG_RECOVER),
    .done_o (rec_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      SG_PROTECT: begin
        if (batt_s)       state_d = SG_BATTERY;
        else if (!fail_s) state_d = SG_RECOVER;
      end
      SG_BATTERY: begin
        if (!batt_s) state_d = SG_PROTECT;
      end
      SG_RECOVER: begin
        if (batt_s)        state_d = SG_BATTERY;
        else if (fail_s)   state_d = SG_PROTECT;
        else if (rec_done) state_d = SG_NORMAL;
      end
      default: begin
        if (batt_s)      state_d = SG_BATTERY;
        else if (fail_s) state_d = SG_PROTECT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SG_PROTECT;
    else     state_q <= state_d;
  end

  sg_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .cur_i  (state_q),
    .nxt_i  (state_d),
    .ctl_o  (ctl),
    .halt_o (halt_set_o)
  );

  assign sys_rst_n_o    = ctl.rst_n;
  assign ram_ce_block_o = ctl.ram_block;
  assign reg_inhibit_o  = ctl.reg_inhibit;
  assign bat_sel_o      = ctl.bat_sel;
  assign out_en_o       = ctl.out_en;

  // R2
  fail_protects_chk: assert property (@(posedge clk) disable iff (rst)
    fail_s |=> (!sys_rst_n_o && ram_ce_block_o && reg_inhibit_o));

  // R5
  batt_tristate_chk: assert property (@(posedge clk) disable iff (rst)
    batt_s |=> (bat_sel_o && !out_en_o && !sys_rst_n_o));

  // R3
  release_from_recover_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n_o) |-> ($past(state_q) == SG_RECOVER));

  // R9
  normal_open_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SG_NORMAL) |-> (!fail_s || $past(fail_s) == 1'b0 || !sys_rst_n_o)
                               && out_en_o && !bat_sel_o);

endmodule

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;

  localparam int REC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pf_r = 1'b1;
  logic sw_r = 1'b0;
  logic rst_n, blk, inh, bat, oe, halt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int m_mode;
  int m_cnt;
  logic m_s1pf, m_s1sw, m_s2pf, m_s2sw, m_halt;

  always #5 clk = ~clk;

  supply_guard #(.REC_CYCLES(REC)) u_supply_guard (
    .clk            (clk),
    .rst            (rst),
    .vcc_fail_i     (pf_r),
    .vcc_batt_i     (sw_r),
    .sys_rst_n_o    (rst_n),
    .ram_ce_block_o (blk),
    .reg_inhibit_o  (inh),
    .bat_sel_o      (bat),
    .out_en_o       (oe),
    .halt_set_o     (halt)
  );

  // modes: 0 normal, 1 protect, 2 battery, 3 recover
  function automatic logic [4:0] exp_ctl(int mode);
    case (mode)
      0:       return 5'b10001;
      2:       return 5'b01110;
      default: return 5'b01101;
    endcase
  endfunction

  function automatic int next_mode(int mode, logic f, logic b, int cnt);
    case (mode)
      1: return b ? 2 : (!f ? 3 : 1);
      2: return b ? 2 : 1;
      3: return b ? 2 : (f ? 1 : ((cnt == REC - 1) ? 0 : 3));
      default: return b ? 2 : (f ? 1 : 0);
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 1; m_cnt = 0; m_halt = 1'b0;
    m_s1pf = 1'b1; m_s1sw = 1'b0; m_s2pf = 1'b1; m_s2sw = 1'b0;
  endtask

  task automatic model_adv();
    int nm;
    nm = next_mode(m_mode, m_s2pf, m_s2sw, m_cnt);
    m_halt = (nm == 3) && (m_mode != 3);
    m_cnt  = (m_mode == 3) ? m_cnt + 1 : 0;
    m_mode = nm;
    m_s2pf = m_s1pf; m_s2sw = m_s1sw;
    m_s1pf = pf_r;   m_s1sw = sw_r;
  endtask

  task automatic model_cmp();
    logic [4:0] e;
    string tag;
    e = exp_ctl(m_mode);
    tag = (m_mode == 0) ? "R9" : ((m_mode == 2) ? "R5" : "R2");
    chk(tag, rst_n, e[4]);
    chk(tag, blk,   e[3]);
    chk(tag, inh,   e[2]);
    chk(tag, bat,   e[1]);
    chk(tag, oe,    e[0]);
    chk("R7", halt, m_halt);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_adv();
      @(negedge clk);
      model_cmp();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    // R8: state held under reset
    chk("R8", rst_n, 1'b0); chk("R8", blk, 1'b1); chk("R8", inh, 1'b1);
    chk("R8", bat, 1'b0);   chk("R8", oe, 1'b1);  chk("R8", halt, 1'b0);
    rst = 1'b0;
    tick(5);
    chk("R2", rst_n, 1'b0);

    // R3 / R7: exact release edge from steady protection
    pf_r = 1'b0;
    tick(2);
    chk("R7", halt, 1'b0);
    tick(1);
    chk("R7", halt, 1'b1);
    tick(1);
    chk("R7", halt, 1'b0);
    tick(REC - 2);
    chk("R3", rst_n, 1'b0); chk("R3", inh, 1'b1);
    tick(1);
    chk("R3", rst_n, 1'b1); chk("R3", inh, 1'b0); chk("R3", blk, 1'b0);
    tick(3);
    chk("R9", oe, 1'b1);

    // R1: three-edge latency from normal
    pf_r = 1'b1;
    tick(2);
    chk("R1", rst_n, 1'b1);
    tick(1);
    chk("R1", rst_n, 1'b0);
    tick(4);

    // R4: one-cycle glitch during recovery restarts the interval
    pf_r = 1'b0;
    tick(12);
    pf_r = 1'b1;
    tick(1);
    pf_r = 1'b0;
    tick(2 + REC);
    chk("R4", rst_n, 1'b0);
    tick(1);
    chk("R4", rst_n, 1'b1);

    // R5 / R6: deep dip, then partial return
    pf_r = 1'b1; sw_r = 1'b1;
    tick(3);
    chk("R5", bat, 1'b1); chk("R5", oe, 1'b0); chk("R5", rst_n, 1'b0);
    tick(5);
    sw_r = 1'b0;
    tick(3);
    chk("R6", bat, 1'b0); chk("R6", oe, 1'b1); chk("R6", rst_n, 1'b0);
    tick(REC + 10);
    chk("R6", rst_n, 1'b0); chk("R6", inh, 1'b1);
    pf_r = 1'b0;
    tick(REC + 5);
    chk("R9", rst_n, 1'b1);

    // random dips and returns
    for (int it = 0; it < 250; it++) begin
      int r;
      int len;
      r = int'($urandom % 8);
      case (r)
        0, 1, 2, 3: begin pf_r = 1'b0; sw_r = 1'b0; len = int'($urandom % (REC + 10)) + 1; end
        4, 5:       begin pf_r = 1'b1; sw_r = 1'b0; len = int'($urandom % 8) + 1; end
        6:          begin pf_r = 1'b1; sw_r = 1'b1; len = int'($urandom % 8) + 1; end
        default:    begin pf_r = 1'b0; sw_r = 1'b0; len = int'($urandom % 5) + 1; end
      endcase
      tick(len);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule